// File: doc/BRIEF.md
# Read-Clear Interrupt Status Controller

This block holds the interrupt word of a 10/100 Ethernet transceiver's management space. Eight event sources feed it: jabber, receive error, page received, parallel detect fault, link partner acknowledge, link status, remote fault and auto-negotiation complete. Each event is captured in a sticky status bit. The status bits sit in the low half of one 16-bit word. The high half holds one interrupt enable per status bit.

Software reaches the word through a plain read/write strobe port. A read returns the whole word and clears every status bit in the same step. A write changes only the enables. The block can be used in two ways. In polled use, software reads the word and never looks at the interrupt pin. In interrupt-driven use, software waits for the interrupt output, whose active level comes from a polarity input. Most sources set their bit whenever they are high. The receive-error source sets its bit only on a rising edge. The link source sets its bit only when the link drops from OK to FAIL.

Top module: `irq_stat_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, all enables and status bits become 0, `rd_data` becomes 0 and `irq` takes its inactive level (the inverse of `irq_pol_hi`).
- R2: A write (`wr_en` high at an edge) loads `wr_data[15:8]` into the enable byte, and the next read returns that byte in `rd_data[15:8]`.
- R3: Writes have no effect on the status byte: `wr_data[7:0]` is ignored, and a status bit is neither set nor cleared by a write.
- R4: The level-qualified sources (`src_evt` bits 7 jabber, 5 page received, 4 parallel detect fault, 3 partner acknowledge, 1 remote fault, 0 negotiation complete) set their status bit at any edge where they are high, and the bit stays set after the source falls until a read.
- R5: Status bit 6 (receive error) sets only when `src_evt[6]` is high at an edge after being low at the previous edge; holding it high does not set it again after a read.
- R6: Status bit 2 (link status change) sets only when `src_evt[2]` (link OK level) is low at an edge after being high at the previous edge; a rise of the link does not set it.
- R7: A read (`rd_en` high at an edge) puts {enables, status} as they were before that edge into `rd_data` at that edge, and clears the status bits at that edge. `rd_data` holds its value until the next read.
- R8: An event that qualifies at the same edge as a read leaves its status bit set after that read, so the next read reports it.
- R9: `irq` is registered and, from the edge at which status and enables are updated, is active whenever (status AND enables) is non-zero. Active means high when `irq_pol_hi` = 1 and low when `irq_pol_hi` = 0.
- R10: A status bit whose enable is 0 never makes `irq` active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read strobe; captures the word and clears status |
| wr_en | input | 1 | Write strobe; loads the enable byte |
| wr_data | input | 16 | Write data; only bits 15:8 are used |
| rd_data | output | 16 | Registered read data {enables, status} |
| src_evt | input | 8 | Event sources; bit 6 is the receive-error level, bit 2 is the link OK level |
| irq_pol_hi | input | 1 | 1 makes `irq` active high, 0 makes it active low |
| irq | output | 1 | Registered interrupt output |

## Verification
A status bit that is lost or stuck shows up at `irq` at the very edge where the event qualifies or the read clears it, provided its enable is set. It also shows up in `rd_data` one edge after the next read strobe. A stale edge-detector history has a different signature. A receive-error bit appears again after a read while the source is held high, or a link bit appears on a rise. Either one is visible at the next read. The sweep walks every source under every enable pattern and both polarities, so a swapped gate or an inverted level shows up within a few cycles of the pulse.

// File: rtl/irq_pkg.sv
`timescale 1ns/1ps
package irq_pkg;

  // Bit positions of the event sources in the status byte
  typedef enum int unsigned {
    SRC_ANEG_DONE = 0,
    SRC_RFAULT    = 1,
    SRC_LINK      = 2,
    SRC_LP_ACK    = 3,
    SRC_PD_FAULT  = 4,
    SRC_PAGE_RX   = 5,
    SRC_RX_ERR    = 6,
    SRC_JABBER    = 7
  } src_idx_e;

  localparam int unsigned SRC_COUNT = 8;

  // Qualification masks: which sources set on an edge rather than a level
  localparam logic [SRC_COUNT-1:0] RISE_QUAL = SRC_COUNT'(1) << SRC_RX_ERR;
  localparam logic [SRC_COUNT-1:0] FALL_QUAL = SRC_COUNT'(1) << SRC_LINK;

endpackage

// File: rtl/irq_evt_qual.sv
`timescale 1ns/1ps
// Turns raw source levels into single set requests, per-bit qualified
module irq_evt_qual #(
  parameter int unsigned N = 8,
  parameter logic [N-1:0] RISE_MASK = '0,
  parameter logic [N-1:0] FALL_MASK = '0
) (
  input  logic         clk,
  input  logic [N-1:0] src_i,
  output logic [N-1:0] set_o
);

  // History of each source; tracks the input every cycle, reset or not
  logic [N-1:0] prev_q;

  always_ff @(posedge clk) begin
    prev_q <= src_i;
  end

  for (genvar i = 0; i < N; i++) begin : g_bit
    if (RISE_MASK[i]) begin : g_rise
      assign set_o[i] = src_i[i] & ~prev_q[i];
    end else if (FALL_MASK[i]) begin : g_fall
      assign set_o[i] = ~src_i[i] & prev_q[i];
    end else begin : g_level
      assign set_o[i] = src_i[i];
    end
  end

endmodule

// File: rtl/irq_stat_bank.sv
`timescale 1ns/1ps
// Sticky status bits: set wins over read-clear in the same cycle
module irq_stat_bank #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic         clr_i,
  output logic [N-1:0] stat_o,
  output logic [N-1:0] stat_nxt_o
);

  logic [N-1:0] stat_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    assign stat_nxt_o[i] = set_i[i] | (stat_q[i] & ~clr_i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
    end else begin
      stat_q <= stat_nxt_o;
    end
  end

  assign stat_o = stat_q;

endmodule

// File: rtl/irq_en_reg.sv
`timescale 1ns/1ps
// Interrupt enable byte, written from the upper half of the write word
module irq_en_reg #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] en_o,
  output logic [N-1:0] en_nxt_o
);

  logic [N-1:0] en_q;

  assign en_nxt_o = wr_i ? wdata_i : en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= '0;
    end else begin
      en_q <= en_nxt_o;
    end
  end

  assign en_o = en_q;

endmodule

// File: rtl/irq_out_drv.sv
`timescale 1ns/1ps
// Registered interrupt pin with selectable active level
module irq_out_drv #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         pol_hi_i,
  input  logic [N-1:0] stat_nxt_i,
  input  logic [N-1:0] en_nxt_i,
  output logic         irq_o
);

  logic pending;
  logic irq_q;

  assign pending = |(stat_nxt_i & en_nxt_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= ~pol_hi_i;
    end else begin
      irq_q <= pol_hi_i ? pending : ~pending;
    end
  end

  assign irq_o = irq_q;

endmodule

// File: rtl/irq_stat_ctrl.sv
`timescale 1ns/1ps
module irq_stat_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned SRC_N = SRC_COUNT,
  parameter logic [SRC_N-1:0] RISE_MASK = RISE_QUAL,
  parameter logic [SRC_N-1:0] FALL_MASK = FALL_QUAL,
  localparam int unsigned WORD_W = 2 * SRC_N
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] rd_data,
  input  logic [SRC_N-1:0]  src_evt,
  input  logic              irq_pol_hi,
  output logic              irq
);

  logic [SRC_N-1:0] set_vec;
  logic [SRC_N-1:0] stat_q;
  logic [SRC_N-1:0] stat_nxt;
  logic [SRC_N-1:0] en_q;
  logic [SRC_N-1:0] en_nxt;
  logic [WORD_W-1:0] rd_q;
  logic wr_lo_unused;

  assign wr_lo_unused = ^wr_data[SRC_N-1:0];

  irq_evt_qual #(
    .N(SRC_N), .RISE_MASK(RISE_MASK), .FALL_MASK(FALL_MASK)
  ) u_qual (
    .clk  (clk),
    .src_i(src_evt),
    .set_o(set_vec)
  );

  irq_stat_bank #(.N(SRC_N)) u_stat (
    .clk       (clk),
    .rst       (rst),
    .set_i     (set_vec),
    .clr_i     (rd_en),
    .stat_o    (stat_q),
    .stat_nxt_o(stat_nxt)
  );

  irq_en_reg #(.N(SRC_N)) u_en (
    .clk     (clk),
    .rst     (rst),
    .wr_i    (wr_en),
    .wdata_i (wr_data[WORD_W-1:SRC_N]),
    .en_o    (en_q),
    .en_nxt_o(en_nxt)
  );

  irq_out_drv #(.N(SRC_N)) u_out (
    .clk       (clk),
    .rst       (rst),
    .pol_hi_i  (irq_pol_hi),
    .stat_nxt_i(stat_nxt),
    .en_nxt_i  (en_nxt),
    .irq_o     (irq)
  );

  // Read data capture: pre-clear snapshot of the whole word
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= '0;
    end else if (rd_en) begin
      rd_q <= {en_q, stat_q};
    end
  end

  assign rd_data = rd_q;

endmodule

// File: rtl/irq_stat_ctrl_chk.sv
`timescale 1ns/1ps
module irq_stat_ctrl_chk #(
  parameter int unsigned N = 8
) (
  input logic           clk,
  input logic           rst,
  input logic           rd_en,
  input logic           wr_en,
  input logic [2*N-1:0] wr_data,
  input logic [2*N-1:0] rd_data,
  input logic [N-1:0]   src_evt,
  input logic           irq_pol_hi,
  input logic           irq,
  input logic [N-1:0]   set_vec,
  input logic [N-1:0]   stat_q,
  input logic [N-1:0]   en_q
);

  p_en_load_r2: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> en_q == $past(wr_data[2*N-1:N]));

  p_no_wr_stat_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !rd_en && set_vec == '0) |=> stat_q == $past(stat_q));

  p_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> (stat_q & $past(stat_q)) == $past(stat_q));

  p_rx_rise_r5: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !(src_evt[6] && !$past(src_evt[6]))) |=> !stat_q[6]);

  p_link_fall_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !(!src_evt[2] && $past(src_evt[2]))) |=> !stat_q[2]);

  p_read_word_r7: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_data == {$past(en_q), $past(stat_q)});

  p_hold_rd_r7: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));

  p_evt_kept_r8: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> (stat_q & $past(set_vec)) == $past(set_vec));

  p_irq_level_r9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> irq == ($past(irq_pol_hi) ? (|(stat_q & en_q)) : !(|(stat_q & en_q))));

  p_gate_r10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((stat_q & en_q) == '0) -> (irq == !$past(irq_pol_hi)));

endmodule

bind irq_stat_ctrl irq_stat_ctrl_chk #(.N(SRC_N)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .rd_en     (rd_en),
  .wr_en     (wr_en),
  .wr_data   (wr_data),
  .rd_data   (rd_data),
  .src_evt   (src_evt),
  .irq_pol_hi(irq_pol_hi),
  .irq       (irq),
  .set_vec   (set_vec),
  .stat_q    (stat_q),
  .en_q      (en_q)
);

// File: tb/tb_irq_stat_ctrl.sv
`timescale 1ns/1ps
module tb_irq_stat_ctrl;

  localparam logic [7:0] RISE_M = 8'h40;
  localparam logic [7:0] FALL_M = 8'h04;
  localparam logic [7:0] LVL_M  = ~(RISE_M | FALL_M);

  logic        clk = 1'b0;
  logic        rst;
  logic        rd_en, wr_en;
  logic [15:0] wr_data;
  logic [15:0] rd_data;
  logic [7:0]  src_evt;
  logic        irq_pol_hi;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // Bench-side expectation state
  logic [7:0] men, mst, mp;

  always #10 clk = ~clk;

  irq_stat_ctrl dut (
    .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .src_evt(src_evt), .irq_pol_hi(irq_pol_hi), .irq(irq)
  );

  task automatic chk(input string tag, input logic [15:0] a, input logic [15:0] e);
    total++;
    if (a !== e) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, a, e);
    end
  endtask

  // One clock: drive at falling edge, sample 5 ns after the rising edge
  task automatic cyc(input logic rd, input logic wr, input logic [15:0] wd,
                     input logic [7:0] s);
    logic [7:0]  setv;
    logic [15:0] exp_rd;
    logic        act;
    @(negedge clk);
    rd_en = rd; wr_en = wr; wr_data = wd; src_evt = s;
    setv   = (s & LVL_M) | (s & ~mp & RISE_M) | (~s & mp & FALL_M);
    exp_rd = {men, mst};
    mst    = (rd ? 8'h00 : mst) | setv;
    if (wr) men = wd[15:8];
    mp = s;
    @(posedge clk); #5;
    act = |(mst & men);
    chk("R9 irq level", {15'd0, irq}, {15'd0, irq_pol_hi ? act : !act});
    if (rd) chk("R7 read word", rd_data, exp_rd);
    rd_en = 1'b0; wr_en = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; rd_en = 0; wr_en = 0; wr_data = '0; src_evt = '0; irq_pol_hi = 0;
    men = '0; mst = '0; mp = '0;
    repeat (4) @(posedge clk);
    #5;
    chk("R1 reset rd_data", rd_data, 16'h0000);
    chk("R1 reset irq inactive low-pol", {15'd0, irq}, 16'h0001);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #5;
    cyc(1, 0, 16'h0, 8'h00);
    chk("R1 word zero after reset", rd_data, 16'h0000);

    // R2: enable write and read-back
    cyc(0, 1, 16'hA5_00, 8'h00);
    cyc(1, 0, 16'h0, 8'h00);
    chk("R2 enable readback", rd_data, 16'hA500);

    // R3: status byte ignores writes (set then write zeros/ones)
    cyc(0, 1, 16'h0000, 8'h00);
    cyc(0, 1, 16'h00FF, 8'h00);
    cyc(1, 0, 16'h0, 8'h00);
    chk("R3 write ones ignored", rd_data, 16'h0000);
    cyc(0, 0, 16'h0, 8'h81);
    cyc(0, 1, 16'h0000, 8'h00);
    cyc(1, 0, 16'h0, 8'h00);
    chk("R3 write zeros ignored", rd_data, 16'h0081);

    // R4: level source sticky after it drops
    cyc(0, 0, 16'h0, 8'h80);
    cyc(0, 0, 16'h0, 8'h00);
    cyc(0, 0, 16'h0, 8'h00);
    cyc(1, 0, 16'h0, 8'h00);
    chk("R4 sticky jabber", rd_data, 16'h0080);

    // R5: receive error held high sets once
    cyc(0, 0, 16'h0, 8'h40);
    cyc(0, 0, 16'h0, 8'h40);
    cyc(1, 0, 16'h0, 8'h40);
    chk("R5 first rise", rd_data, 16'h0040);
    cyc(0, 0, 16'h0, 8'h40);
    cyc(1, 0, 16'h0, 8'h40);
    chk("R5 held level no reset", rd_data, 16'h0000);
    cyc(0, 0, 16'h0, 8'h00);

    // R6: link rise does not set, link fall does
    cyc(0, 0, 16'h0, 8'h04);
    cyc(0, 0, 16'h0, 8'h04);
    cyc(1, 0, 16'h0, 8'h04);
    chk("R6 link rise ignored", rd_data, 16'h0000);
    cyc(0, 0, 16'h0, 8'h00);
    cyc(1, 0, 16'h0, 8'h00);
    chk("R6 link fall sets", rd_data, 16'h0004);

    // R8: event coinciding with read survives it
    cyc(1, 0, 16'h0, 8'h01);
    chk("R8 read shows pre-event", rd_data, 16'h0000);
    cyc(1, 0, 16'h0, 8'h00);
    chk("R8 event kept", rd_data, 16'h0001);

    // R10: disabled status never asserts irq
    cyc(0, 1, 16'h0100, 8'h00);
    cyc(0, 0, 16'h0, 8'h02);
    chk("R10 gated irq inactive", {15'd0, irq}, 16'h0001);
    cyc(1, 0, 16'h0, 8'h00);

    // Sweep: every source, four enable patterns, both polarities
    for (int pol = 0; pol < 2; pol++) begin
      irq_pol_hi = pol[0];
      for (int k = 0; k < 8; k++) begin
        for (int e = 0; e < 4; e++) begin
          logic [7:0] bit_k;
          logic [7:0] enp;
          bit_k = 8'(1) << k;
          case (e)
            0: enp = 8'h00;
            1: enp = bit_k;
            2: enp = ~bit_k;
            default: enp = 8'hFF;
          endcase
          cyc(1, 0, 16'h0, 8'h00);
          cyc(0, 1, {enp, 8'h00}, 8'h00);
          cyc(0, 0, 16'h0, bit_k);
          cyc(0, 0, 16'h0, 8'h00);
          chk("R9 sweep irq after event", {15'd0, irq},
              {15'd0, ((enp & bit_k) != 0) ? pol[0] : !pol[0]});
          cyc(0, 0, 16'h0, 8'h00);
          cyc(1, 0, 16'h0, 8'h00);
          chk("R4 sweep status bit", rd_data, {enp, bit_k});
          cyc(0, 0, 16'h0, 8'h00);
        end
      end
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule